// File: doc/BRIEF.md
# Signed Array Multiplier with Complemented Sign Terms

This block multiplies two 5-bit two's-complement operands and returns the full 10-bit two's-complement product, with no clock and no state. Each operand's top bit weighs -16, and the product's top bit weighs -512. Any pair of operands, including both at -16, fits in the result without overflow.

The datapath is a regular grid of identical cells. Each cell forms one bit product with a gate and adds it to a sum arriving from the row above and a carry, using a full adder. Carries pass straight down the grid. A ripple-carry row then merges the last sums and carries into the upper half of the product. The gate in a cell is a NAND, not an AND, when exactly one of its two operand bits is a sign bit. A constant one enters at column 5 and a second at column 9. Together these make the sign correction, so no cells are spent on sign extension. The operand width is a parameter with a default of 5.

A user places the block wherever a signed product is needed within one combinational path. The longest path crosses about twice the operand width in full-adder cells.

Top module: `bw_array_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the two's-complement product of `mcand_i` and `mplier_i`. Both operands are 5-bit values in the range -16 to +15, and the product is a 10-bit value.
- R2: When both operands are -16 (5'b10000), `prod_o` is +256 (10'h100), with bit 9 clear.
- R3: When either operand is zero, `prod_o` is zero.
- R4: When `mplier_i` is +1 (5'b00001), `prod_o` is `mcand_i` sign-extended to 10 bits.
- R5: When `mplier_i` is -1 (5'b11111), `prod_o` is the 10-bit negation of the sign-extended `mcand_i`.
- R6: When the product is nonzero, bit 9 of `prod_o` equals the XOR of the two operand sign bits (bit 4 of each operand).
- R7: Swapping the two operands leaves `prod_o` unchanged.
- R8: The block holds no state. `prod_o` follows a change on the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 5 | Multiplicand, two's complement |
| mplier_i | input | 5 | Multiplier, two's complement |
| prod_o | output | 10 | Product, two's complement |

## Verification
The checks in the checker module are immediate checks inside combinational processes. They assume that both operand inputs hold known 0/1 values and that the evaluation sees the settled grid output, not a partly propagated one. The bench therefore drives every operand from a known value from time zero. It changes the operands only once per clock cycle and reads the product half a cycle later, except in the single R8 check, which waits a short delay with no edge in between. Because the sweep covers all 1024 operand pairs, every cell and every constant injection is exercised, and both sign bits are set together in 256 of those pairs.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  // three-input full adder
  function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
    fa_out_t r;
    r.sum   = x ^ y ^ z;
    r.carry = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/bw_cell.sv
module bw_cell
  import bw_mult_pkg::*;
#(
  parameter bit SIGN_TERM = 1'b0
) (
  input  logic mcand_bit,
  input  logic mplier_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);

  logic    term;
  fa_out_t add_res;

  generate
    if (SIGN_TERM) begin : g_nand
      assign term = ~(mcand_bit & mplier_bit);
    end else begin : g_and
      assign term = mcand_bit & mplier_bit;
    end
  endgenerate

  always_comb begin
    add_res = full_add(term, sum_in, carry_in);
  end

  assign sum_out   = add_res.sum;
  assign carry_out = add_res.carry;

endmodule

// File: rtl/bw_ripple_add.sv
module bw_ripple_add
  import bw_mult_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      if (k < WIDTH - 1) begin : g_mid
        fa_out_t r;
        always_comb r = full_add(op_x[k], op_y[k], chain[k]);
        assign sum_o[k]     = r.sum;
        assign chain[k + 1] = r.carry;
      end else begin : g_top
        // carry out of the top column is dropped
        assign sum_o[k] = op_x[k] ^ op_y[k] ^ chain[k];
      end
    end
  endgenerate

endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] row_sum   [WIDTH];
  logic [WIDTH-1:0] row_carry [WIDTH];
  logic [WIDTH-1:0] fin_x;
  logic [WIDTH-1:0] fin_y;
  logic [WIDTH-1:0] fin_s;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_row
      for (genvar j = 0; j < WIDTH; j++) begin : g_col
        localparam bit SIGNED_TERM = (i == WIDTH - 1) ^ (j == WIDTH - 1);
        logic s_in;
        logic c_in;
        if (i == 0) begin : g_top_row
          assign s_in = 1'b0;
          assign c_in = 1'b0;
        end else begin : g_inner_row
          assign c_in = row_carry[i-1][j];
          if (j == WIDTH - 1) begin : g_left
            // first constant one enters at column WIDTH
            assign s_in = (i == 1) ? 1'b1 : 1'b0;
          end else begin : g_body
            assign s_in = row_sum[i-1][j+1];
          end
        end
        bw_cell #(.SIGN_TERM(SIGNED_TERM)) u_cell (
          .mcand_bit (mcand_i[j]),
          .mplier_bit(mplier_i[i]),
          .sum_in    (s_in),
          .carry_in  (c_in),
          .sum_out   (row_sum[i][j]),
          .carry_out (row_carry[i][j])
        );
      end
      assign prod_o[i] = row_sum[i][0];
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_fin
      if (k < WIDTH - 1) begin : g_lo
        assign fin_x[k] = row_sum[WIDTH-1][k+1];
      end else begin : g_hi
        // second constant one enters at column PW-1
        assign fin_x[k] = 1'b1;
      end
      assign fin_y[k] = row_carry[WIDTH-1][k];
    end
  endgenerate

  bw_ripple_add #(.WIDTH(WIDTH)) u_final (
    .op_x (fin_x),
    .op_y (fin_y),
    .sum_o(fin_s)
  );

  assign prod_o[PW-1:WIDTH] = fin_s;

endmodule

// File: rtl/bw_array_mult_chk.sv
module bw_array_mult_chk #(
  parameter int WIDTH = 5
) (
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic [2*WIDTH-1:0] prod_o
);

  localparam int PW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] PLUS_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0]    NEG_SQ   = {2'b01, {(PW-2){1'b0}}};

  logic signed [PW-1:0] ext_a;
  logic signed [PW-1:0] ext_b;
  logic signed [PW-1:0] ref_p;

  always_comb begin
    ext_a = $signed({{WIDTH{mcand_i[WIDTH-1]}}, mcand_i});
    ext_b = $signed({{WIDTH{mplier_i[WIDTH-1]}}, mplier_i});
    ref_p = ext_a * ext_b;
  end

  always_comb begin
    p_product_r1: assert (prod_o == ref_p);
    // R2
    p_most_neg_sq_r2: assert (!(mcand_i == MOST_NEG && mplier_i == MOST_NEG) || prod_o == NEG_SQ);
    p_zero_r3: assert (!(mcand_i == '0 || mplier_i == '0) || prod_o == '0);
    p_unit_r4: assert (mplier_i != PLUS_ONE || prod_o == ext_a);
    p_neg_unit_r5: assert (mplier_i != '1 || prod_o == PW'(-ext_a));
    p_sign_r6: assert (prod_o == '0 || prod_o[PW-1] == (mcand_i[WIDTH-1] ^ mplier_i[WIDTH-1]));
  end

endmodule

bind bw_array_mult bw_array_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .mcand_i (mcand_i),
  .mplier_i(mplier_i),
  .prod_o  (prod_o)
);

// File: tb/tb_bw_array_mult.sv
module tb_bw_array_mult;

  localparam int W  = 5;
  localparam int PW = 2 * W;
  localparam int N  = 1 << W;

  logic          clk = 1'b0;
  logic [W-1:0]  mcand;
  logic [W-1:0]  mplier;
  logic [PW-1:0] prod;

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] seen [N*N];

  always #4 clk = ~clk;

  bw_array_mult #(.WIDTH(W)) dut (
    .mcand_i (mcand),
    .mplier_i(mplier),
    .prod_o  (prod)
  );

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, $signed(mcand), $signed(mplier), act, exp);
    end
  endtask

  function automatic logic [PW-1:0] smul(input int x, input int y);
    int p;
    p = x * y;
    return p[PW-1:0];
  endfunction

  function automatic int sval(input int code);
    return (code >= N/2) ? code - N : code;
  endfunction

  initial begin
    mcand  = '0;
    mplier = '0;
    #1;
    chk("R3 initial zero", prod, '0);
    for (int ia = 0; ia < N; ia++) begin
      for (int ib = 0; ib < N; ib++) begin
        int va;
        int vb;
        @(posedge clk);
        mcand  = W'(ia);
        mplier = W'(ib);
        va = sval(ia);
        vb = sval(ib);
        @(negedge clk);
        seen[ia*N+ib] = prod;
        chk("R1", prod, smul(va, vb));
        if (va == -N/2 && vb == -N/2) chk("R2", prod, 10'h100);
        if (va == 0 || vb == 0) chk("R3", prod, '0);
        if (vb == 1) chk("R4", prod, smul(va, 1));
        if (vb == -1) chk("R5", prod, smul(-va, 1));
        if (va != 0 && vb != 0) chk("R6", {9'b0, prod[PW-1]}, {9'b0, (va < 0) ^ (vb < 0)});
      end
    end
    for (int ia = 0; ia < N; ia++)
      for (int ib = ia + 1; ib < N; ib++)
        chk("R7 commutative", seen[ia*N+ib], seen[ib*N+ia]);
    // R8: output follows inputs with no clock edge in between
    @(posedge clk);
    #1;
    mcand  = 5'b00111;
    mplier = 5'b11101;
    #1;
    chk("R8 no clock", prod, smul(7, -3));
    mcand  = 5'b01111;
    mplier = 5'b01111;
    #1;
    chk("R8 no clock", prod, smul(15, 15));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule